// File: doc/BRIEF.md
# Exception Escalation and Trap Sequencer

This block sits between the sources of exception requests and the handler-entry logic of a processor core. Each cycle it looks at a fault request, a trap request, the end of an instruction with the trap flag, and a pending external interrupt. It then decides which one, if any, is handed to handler entry. It reports the vector to deliver, whether the saved return address is the current instruction or the next one, and a one-cycle strobe that tells the flags logic to drop the trap flag.

The sequencer tracks how deeply exception handling is nested. A second exception raised before the first handler returns is turned into vector 8, the double fault. A third one, raised inside the double-fault handler, stops all delivery and holds a reset request until the block itself is reset. A vector above the programmed table limit also escalates. Single-step traps are ordered so that a pending external interrupt gets in between single-step entry and the first handler instruction.

Top module: `exc_seq_top`

## Requirements
- R1: After reset, and after any reset that ends a shutdown, all outputs are low, nesting is at the normal level, and no trap is held.
- R2: A fault request at the normal level whose vector is not above `vec_limit` is delivered in the next cycle with that vector, with `dlv_ret_next` = 0 (return to the faulting instruction). The sequencer then counts a handler as active.
- R3: A trap request under the same conditions is delivered with `dlv_ret_next` = 1 (return to the following instruction).
- R4: Any exception raised while an exception handler is active is delivered as vector 8 with `dlv_ret_next` = 0, and the sequencer enters the double-fault level.
- R5: Any exception at the double-fault level delivers nothing and enters shutdown. In shutdown `reset_req` stays at 1 and `dlv_valid` stays at 0 whatever the inputs do, including `handler_ret`. Only `rst_n` leaves shutdown.
- R6: A selected vector strictly greater than `vec_limit` is delivered as vector 8 and enters the double-fault level. This applies to exceptions and to external interrupts. A vector equal to the limit is delivered unchanged.
- R7: A `handler_ret` pulse moves the handler level back to normal and also moves the double-fault level back to normal. The next exception is then delivered with its own vector.
- R8: At the normal level, `insn_done` with `trap_flag` = 1 and no fault or trap request delivers vector 1 with `dlv_ret_next` = 1 and `tf_clear` = 1. `tf_clear` lasts one cycle. In that cycle the single step wins over a pending external interrupt.
- R9: In the cycle right after a single-step delivery, a pending external interrupt is accepted without `insn_done`: `dlv_vec` = `irq_vec`, `irq_ack` = 1, `dlv_ret_next` = 0. One cycle later that window has closed.
- R10: Outside that window, an external interrupt is accepted only together with `insn_done`, at any handler level below shutdown. An accepted interrupt does not change the nesting level.
- R11: When a fault and a trap are requested in the same cycle at the normal level, the fault is delivered first and the trap is held. The held trap is delivered, with `dlv_ret_next` = 1, in the cycle after the sequencer is next back at the normal level. It is delivered only once.
- R12: An exception request in the same cycle as `handler_ret` is judged at the current level, and the return is ignored.
- R13: No single-step trap is made while a handler is active, even with `insn_done` and `trap_flag` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Fault-class exception request |
| fault_vec | input | VEC_W | Vector of the fault request |
| trap_req | input | 1 | Trap-class exception request |
| trap_vec | input | VEC_W | Vector of the trap request |
| insn_done | input | 1 | An instruction completed this cycle |
| trap_flag | input | 1 | Current value of the single-step trap flag |
| irq_pend | input | 1 | External interrupt pending |
| irq_vec | input | VEC_W | Vector of the pending external interrupt |
| handler_ret | input | 1 | The running exception handler returned |
| vec_limit | input | VEC_W | Highest vector present in the vector table |
| dlv_valid | output | 1 | A vector is delivered this cycle |
| dlv_vec | output | VEC_W | Delivered vector |
| dlv_ret_next | output | 1 | 1: return to the following instruction; 0: return to the current one |
| tf_clear | output | 1 | Strobe to clear the trap flag on single-step entry |
| irq_ack | output | 1 | The pending external interrupt was accepted |
| reset_req | output | 1 | Shutdown reached; reset requested |

## Verification
The hardest case to reach from the ports is the held trap of R11. It needs a fault and a trap in the same cycle at the normal level, then a handler return, and only then an idle cycle in which the held trap comes out without any request being asserted. The stimulus builds it as a fixed sequence. It also checks that the trap does not appear during the handler and does not appear a second time. The single-step window of R9 is reached the same way: interrupt pending with single step, then pending alone for two cycles. Shutdown is reached through an over-limit fault followed by a trap.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  // Handler nesting level of the sequencer
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_HANDLER = 2'd1,
    ST_DFAULT  = 2'd2,
    ST_SHUT    = 2'd3
  } nest_e;

  // Source chosen by the arbiter in a cycle
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_FAULT = 3'd1,
    SEL_TRAP  = 3'd2,
    SEL_PEND  = 3'd3,
    SEL_STEP  = 3'd4,
    SEL_IRQ   = 3'd5
  } src_e;

  // Sources that count as exceptions for nesting purposes
  function automatic logic src_is_exc(input src_e s);
    return (s == SEL_FAULT) || (s == SEL_TRAP) || (s == SEL_PEND) || (s == SEL_STEP);
  endfunction

  // Trap-class sources resume after the instruction that raised them
  function automatic logic src_ret_next(input src_e s);
    return (s == SEL_TRAP) || (s == SEL_PEND) || (s == SEL_STEP);
  endfunction

endpackage

// File: rtl/exc_src_arbiter.sv
module exc_src_arbiter
  import exc_seq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SS_VEC = 1
) (
  input  logic             lvl_normal,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             pend_valid,
  input  logic [VEC_W-1:0] pend_vec,
  input  logic             insn_done,
  input  logic             trap_flag,
  input  logic             ss_window,
  input  logic             irq_pend,
  input  logic [VEC_W-1:0] irq_vec,
  output src_e             sel,
  output logic [VEC_W-1:0] sel_vec,
  output logic             latch_trap
);

  localparam logic [VEC_W-1:0] STEP_VEC = VEC_W'(SS_VEC);

  logic step_ok;
  logic irq_ok;

  // Single step only at the normal level (R13); interrupts at a boundary or in the step window (R9, R10)
  assign step_ok = insn_done && trap_flag && lvl_normal;
  assign irq_ok  = irq_pend && (insn_done || ss_window);

  // Fixed priority: fault, trap, held trap, single step, external interrupt
  always_comb begin
    sel     = SEL_NONE;
    sel_vec = '0;
    if (fault_req) begin
      sel     = SEL_FAULT;
      sel_vec = fault_vec;
    end else if (trap_req) begin
      sel     = SEL_TRAP;
      sel_vec = trap_vec;
    end else if (pend_valid && lvl_normal) begin
      sel     = SEL_PEND;
      sel_vec = pend_vec;
    end else if (step_ok) begin
      sel     = SEL_STEP;
      sel_vec = STEP_VEC;
    end else if (irq_ok) begin
      sel     = SEL_IRQ;
      sel_vec = irq_vec;
    end
  end

  // A trap losing to a simultaneous fault at the normal level is kept (R11)
  assign latch_trap = fault_req && trap_req && lvl_normal;

endmodule

// File: rtl/exc_trap_hold.sv
module exc_trap_hold #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             take,
  output logic             pend_valid,
  output logic [VEC_W-1:0] pend_vec
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_vec   <= '0;
    end else if (set) begin
      pend_valid <= 1'b1;
      pend_vec   <= set_vec;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R11: a held trap is never loaded and consumed in the same cycle
  p_no_set_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set && take));

  // R11: a consumed trap is gone on the next cycle
  p_take_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !set) |=> !pend_valid);

endmodule

// File: rtl/exc_nest_fsm.sv
module exc_nest_fsm
  import exc_seq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             sel,
  input  logic [VEC_W-1:0] sel_vec,
  input  logic [VEC_W-1:0] vec_limit,
  input  logic             handler_ret,
  output nest_e            state,
  output logic             go,
  output logic             dbl,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_ret_next
);

  localparam logic [VEC_W-1:0] DOUBLE_VEC = VEC_W'(DF_VEC);

  nest_e state_q;
  nest_e state_d;
  logic  is_exc;
  logic  is_irq;
  logic  over;
  logic  esc;

  // Vector beyond the programmed table escalates (R6)
  function automatic logic beyond_table(input logic [VEC_W-1:0] v, input logic [VEC_W-1:0] lim);
    return v > lim;
  endfunction

  assign is_exc = src_is_exc(sel);
  assign is_irq = (sel == SEL_IRQ);
  assign over   = beyond_table(sel_vec, vec_limit);
  assign esc    = is_exc || (is_irq && over);

  always_comb begin
    state_d      = state_q;
    go           = 1'b0;
    dbl          = 1'b0;
    out_vec      = sel_vec;
    out_ret_next = src_ret_next(sel);
    unique case (state_q)
      ST_NORMAL: begin
        if (esc) begin
          go = 1'b1;
          if (over) begin
            dbl     = 1'b1;
            state_d = ST_DFAULT;
          end else begin
            state_d = ST_HANDLER;
          end
        end else if (is_irq) begin
          go = 1'b1;
        end
      end
      ST_HANDLER: begin
        if (esc) begin
          go      = 1'b1;
          dbl     = 1'b1;
          state_d = ST_DFAULT;
        end else if (is_irq) begin
          go = 1'b1;
        end else if (handler_ret) begin
          state_d = ST_NORMAL;
        end
      end
      ST_DFAULT: begin
        if (esc) begin
          state_d = ST_SHUT;
        end else if (is_irq) begin
          go = 1'b1;
        end else if (handler_ret) begin
          state_d = ST_NORMAL;
        end
      end
      default: begin
        state_d = ST_SHUT;
      end
    endcase
    if (dbl) begin
      out_vec      = DOUBLE_VEC;
      out_ret_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R5: shutdown is left only through reset
  p_shut_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHUT) |=> (state_q == ST_SHUT));

  // R4: an escalating event while a handler runs reaches the double-fault level
  p_nest_to_df_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HANDLER && esc) |=> (state_q == ST_DFAULT));

  // R7: return from the double-fault handler with nothing else going on lands at normal
  p_df_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DFAULT && handler_ret && sel == SEL_NONE) |=> (state_q == ST_NORMAL));

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned DF_VEC = 8,
  parameter int unsigned SS_VEC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             insn_done,
  input  logic             trap_flag,
  input  logic             irq_pend,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             handler_ret,
  input  logic [VEC_W-1:0] vec_limit,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vec,
  output logic             dlv_ret_next,
  output logic             tf_clear,
  output logic             irq_ack,
  output logic             reset_req
);

  localparam logic [VEC_W-1:0] DOUBLE_VEC = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] STEP_VEC   = VEC_W'(SS_VEC);

  // Named internal events
  nest_e            nest_state;
  src_e             sel;
  logic [VEC_W-1:0] sel_vec;
  logic             latch_trap;
  logic             pend_valid;
  logic [VEC_W-1:0] pend_vec;
  logic             go;
  logic             dbl;
  logic [VEC_W-1:0] out_vec;
  logic             out_ret_next;
  logic             step_taken;
  logic             irq_taken;
  logic             pend_taken;
  logic             ss_window_q;
  logic             lvl_normal;

  assign lvl_normal = (nest_state == ST_NORMAL);

  exc_src_arbiter #(.VEC_W(VEC_W), .SS_VEC(SS_VEC)) u_arb (
    .lvl_normal (lvl_normal),
    .fault_req  (fault_req),
    .fault_vec  (fault_vec),
    .trap_req   (trap_req),
    .trap_vec   (trap_vec),
    .pend_valid (pend_valid),
    .pend_vec   (pend_vec),
    .insn_done  (insn_done),
    .trap_flag  (trap_flag),
    .ss_window  (ss_window_q),
    .irq_pend   (irq_pend),
    .irq_vec    (irq_vec),
    .sel        (sel),
    .sel_vec    (sel_vec),
    .latch_trap (latch_trap)
  );

  exc_nest_fsm #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .sel_vec      (sel_vec),
    .vec_limit    (vec_limit),
    .handler_ret  (handler_ret),
    .state        (nest_state),
    .go           (go),
    .dbl          (dbl),
    .out_vec      (out_vec),
    .out_ret_next (out_ret_next)
  );

  assign step_taken = go && (sel == SEL_STEP) && !dbl;
  assign irq_taken  = go && (sel == SEL_IRQ);
  assign pend_taken = go && (sel == SEL_PEND);

  exc_trap_hold #(.VEC_W(VEC_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (latch_trap),
    .set_vec    (trap_vec),
    .take       (pend_taken),
    .pend_valid (pend_valid),
    .pend_vec   (pend_vec)
  );

  // Registered delivery outputs, one cycle after the deciding inputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid    <= 1'b0;
      dlv_vec      <= '0;
      dlv_ret_next <= 1'b0;
      tf_clear     <= 1'b0;
      irq_ack      <= 1'b0;
      ss_window_q  <= 1'b0;
    end else begin
      dlv_valid    <= go;
      dlv_vec      <= go ? out_vec : '0;
      dlv_ret_next <= go && out_ret_next;
      tf_clear     <= step_taken;
      irq_ack      <= irq_taken;
      ss_window_q  <= step_taken;
    end
  end

  assign reset_req = (nest_state == ST_SHUT);

  // R5: nothing is delivered while reset is requested, and the request stays up
  p_shut_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (reset_req && !dlv_valid));

  // R4: an exception inside an active handler comes out as the double fault
  p_second_is_df_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_state == ST_HANDLER && (fault_req || trap_req)) |=> (dlv_valid && dlv_vec == DOUBLE_VEC && !dlv_ret_next));

  // R8: the trap-flag strobe marks a single-step delivery resuming after the instruction
  p_step_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clear |-> (dlv_valid && dlv_vec == STEP_VEC && dlv_ret_next));

  // R8: the strobe is a single-cycle pulse
  p_step_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clear |=> !tf_clear);

  // R10: an interrupt acknowledge always accompanies a delivery that resumes at the current instruction
  p_ack_delivers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (dlv_valid && !dlv_ret_next));

  // R11: fault beats a simultaneous trap
  p_fault_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_normal && fault_req && trap_req && fault_vec <= vec_limit)
      |=> (dlv_valid && dlv_vec == $past(fault_vec) && !dlv_ret_next));

  // R9: the step window lasts exactly one cycle after the step delivery
  p_window_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_window_q) |=> !ss_window_q);

endmodule

// File: tb/test_exc_seq_top.sv
`timescale 1ns/1ps
module test_exc_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_req = 1'b0;
  logic [7:0] fault_vec = '0;
  logic       trap_req = 1'b0;
  logic [7:0] trap_vec = '0;
  logic       insn_done = 1'b0;
  logic       trap_flag = 1'b0;
  logic       irq_pend = 1'b0;
  logic [7:0] irq_vec = '0;
  logic       handler_ret = 1'b0;
  logic [7:0] vec_limit = 8'h20;
  logic       dlv_valid;
  logic [7:0] dlv_vec;
  logic       dlv_ret_next;
  logic       tf_clear;
  logic       irq_ack;
  logic       reset_req;

  always #5 clk = ~clk;

  exc_seq_top i_exc_seq_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_req    (fault_req),
    .fault_vec    (fault_vec),
    .trap_req     (trap_req),
    .trap_vec     (trap_vec),
    .insn_done    (insn_done),
    .trap_flag    (trap_flag),
    .irq_pend     (irq_pend),
    .irq_vec      (irq_vec),
    .handler_ret  (handler_ret),
    .vec_limit    (vec_limit),
    .dlv_valid    (dlv_valid),
    .dlv_vec      (dlv_vec),
    .dlv_ret_next (dlv_ret_next),
    .tf_clear     (tf_clear),
    .irq_ack      (irq_ack),
    .reset_req    (reset_req)
  );

  typedef struct {
    logic       v;
    logic [7:0] vec;
    logic       rn;
    logic       tc;
    logic       ack;
    logic       rr;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic cyc(input logic fr, input logic [7:0] fv, input logic tr, input logic [7:0] tv,
                     input logic dn, input logic tf, input logic ip, input logic [7:0] iv,
                     input logic hr, input logic ev, input logic [7:0] evec, input logic ern,
                     input logic etc, input logic eack, input logic err, input string req);
    exp_t e;
    @(negedge clk);
    fault_req = fr; fault_vec = fv; trap_req = tr; trap_vec = tv;
    insn_done = dn; trap_flag = tf; irq_pend = ip; irq_vec = iv; handler_ret = hr;
    e.v = ev; e.vec = evec; e.rn = ern; e.tc = etc; e.ack = eack; e.rr = err; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_in();
    fault_req = 0; trap_req = 0; insn_done = 0; trap_flag = 0;
    irq_pend = 0; handler_ret = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compares after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_checks++;
        if ({dlv_valid, dlv_vec, dlv_ret_next, tf_clear, irq_ack, reset_req} !==
            {e.v, e.vec, e.rn, e.tc, e.ack, e.rr}) begin
          n_fails++;
          $display("FAIL %s: got v=%0b vec=%02h rn=%0b tc=%0b ack=%0b rr=%0b, expected v=%0b vec=%02h rn=%0b tc=%0b ack=%0b rr=%0b",
                   e.req, dlv_valid, dlv_vec, dlv_ret_next, tf_clear, irq_ack, reset_req,
                   e.v, e.vec, e.rn, e.tc, e.ack, e.rr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    //  fr fv     tr tv     dn tf ip iv     hr | v vec    rn tc ak rr
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0,   0, 8'h00, 0, 0, 0, 0, "R1 reset state");
    cyc(1, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h00, 0, 0, 0, 0, "R2 fault returns to current");
    cyc(1, 8'h06, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h08, 0, 0, 0, 0, "R4 nested becomes double fault");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 leave double fault");
    cyc(0, 8'h00, 1, 8'h03, 0, 0, 0, 8'h00, 0,   1, 8'h03, 1, 0, 0, 0, "R3 trap returns to next");
    cyc(0, 8'h00, 0, 8'h00, 1, 1, 0, 8'h00, 0,   0, 8'h00, 0, 0, 0, 0, "R13 no step in handler");
    cyc(0, 8'h00, 0, 8'h00, 1, 0, 1, 8'h20, 0,   1, 8'h20, 0, 0, 1, 0, "R10 irq inside handler");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 leave handler");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 1, 8'h1C, 0,   0, 8'h00, 0, 0, 0, 0, "R10 irq waits for boundary");
    cyc(0, 8'h00, 0, 8'h00, 1, 0, 1, 8'h1C, 0,   1, 8'h1C, 0, 0, 1, 0, "R10 irq at boundary");
    cyc(1, 8'h05, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h05, 0, 0, 0, 0, "R10 irq leaves nesting unchanged");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 return");
    cyc(0, 8'h00, 0, 8'h00, 1, 1, 1, 8'h1D, 0,   1, 8'h01, 1, 1, 0, 0, "R8 single step beats irq");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 1, 8'h1D, 0,   1, 8'h1D, 0, 0, 1, 0, "R9 irq in step window");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 1, 8'h1D, 0,   0, 8'h00, 0, 0, 0, 0, "R9 window closed");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 return");
    cyc(1, 8'h00, 1, 8'h03, 0, 0, 0, 8'h00, 0,   1, 8'h00, 0, 0, 0, 0, "R11 fault first");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R11 trap held during handler");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h03, 1, 0, 0, 0, "R11 held trap delivered");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R11 return");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0,   0, 8'h00, 0, 0, 0, 0, "R11 held trap delivered once");
    cyc(1, 8'h0E, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h0E, 0, 0, 0, 0, "R2 fault");
    cyc(1, 8'h0B, 0, 8'h00, 0, 0, 0, 8'h00, 1,   1, 8'h08, 0, 0, 0, 0, "R12 exception beats return");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 leave double fault");
    cyc(1, 8'h04, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h04, 0, 0, 0, 0, "R7 own vector after return");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 return");
    cyc(1, 8'h30, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h08, 0, 0, 0, 0, "R6 over limit escalates");
    cyc(0, 8'h00, 1, 8'h03, 0, 0, 0, 8'h00, 0,   0, 8'h00, 0, 0, 0, 1, "R5 exception in double fault");
    cyc(1, 8'h00, 0, 8'h00, 1, 1, 1, 8'h10, 0,   0, 8'h00, 0, 0, 0, 1, "R5 shutdown ignores inputs");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 1, "R5 return cannot leave shutdown");
    do_reset();
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0,   0, 8'h00, 0, 0, 0, 0, "R1 reset ends shutdown");
    cyc(1, 8'h20, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h20, 0, 0, 0, 0, "R6 vector equal to limit");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 return");
    cyc(0, 8'h00, 0, 8'h00, 1, 0, 1, 8'h21, 0,   1, 8'h08, 0, 0, 1, 0, "R6 irq over limit");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 leave double fault");
    cyc(1, 8'h07, 0, 8'h00, 0, 0, 0, 8'h00, 0,   1, 8'h07, 0, 0, 0, 0, "R7 back to normal");
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 1,   0, 8'h00, 0, 0, 0, 0, "R7 return");
    @(negedge clk);
    idle_in();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule